// File: doc/BRIEF.md
# PCM Time-Slot Assignment Controller

This block places one voice channel into a chosen 8-bit time-slot of a serial PCM frame, separately for the transmit and the receive direction. Each direction has its own bit clock and its own frame-sync marker. The two markers may sit at any bit offset from each other. A bit counter and a slot counter per direction measure the position inside the frame. A comparator against the assigned slot gates the transmit output enable and strobes the captured receive byte.

Assignments are written as two-byte instructions over a byte-wide control port framed by a chip-select. An accepted instruction silences the targeted port at once. The new slot is applied only at the second frame marker of that direction seen after chip-select drops. After reset both directions run in fixed-slot, non-delayed timing. The bit clocks and markers are level inputs synchronous to `clk` and are edge-detected inside the block.

Top module: `pcm_tsa_ctrl`

## Requirements
- R1: After reset both directions are enabled, use slot 0 and non-delayed timing. `tx_oe`, `tx_sdo` and `rx_valid` are low until a frame marker has been seen.
- R2: A frame marker is a bit-clock rising edge where the frame-sync input is high after being low at the previous rising edge. In non-delayed timing, the bit period starting at the marker edge is bit 0 of slot 0.
- R3: In delayed timing, bit 0 of slot 0 starts at the rising edge after the marker edge. Slot n covers frame bits 8n..8n+7. After bit 7 of slot 63 the counters stay idle, with no slot matching, until the next marker.
- R4: `tx_oe` is high for exactly the 8 bit periods of the matching slot and low otherwise. During bit i of the slot (i = 0..7), `tx_sdo` carries `tx_word[7-i]`. `tx_sdo` is 0 while `tx_oe` is low.
- R5: In the matching receive slot, `rx_sdi` is sampled at each bit-clock falling edge, MSB first. After the falling edge of bit 7, `rx_valid` pulses for one `clk` cycle with the byte on `rx_word`.
- R6: An instruction is the byte sequence written with `ctl_wr` while `ctl_cs` is high. The first byte holds opcode 6'b101101 in bits 7:2, the timing select in bit 1 (1 = delayed) and the direction in bit 0 (0 = transmit). The second byte holds enable in bit 7, port-select in bit 6 and the slot number in bits 5:0 (bit 5 MSB). A wrong opcode or a missing second byte leaves everything unchanged. Bytes after the second are ignored.
- R7: A second byte with port-select 0 is rejected: the port stays live with its previous assignment.
- R8: An accepted second byte silences the addressed port from the next `clk` cycle: no `tx_oe` and no `rx_valid`. The other direction is not affected.
- R9: Counting starts with the first marker of the addressed direction strictly after the `clk` cycle in which `ctl_cs` falls. The new enable and slot take effect at the second counted marker, which also starts that frame. The timing select takes effect when the instruction is accepted.
- R10: With enable 0, the port stays silent after activation in every slot.
- R11: With non-delayed timing selected, the slot field is disregarded and slot 0 is used.
- R12: Transmit and receive keep separate counters and registers, and markers at any bit offset from each other are handled independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_cs | input | 1 | Control chip-select, frames one instruction |
| ctl_wr | input | 1 | Control byte strobe |
| ctl_byte | input | 8 | Control byte |
| tx_bclk | input | 1 | Transmit bit clock (level) |
| tx_fs | input | 1 | Transmit frame-sync marker |
| tx_word | input | 8 | Byte to send in the transmit slot |
| tx_sdo | output | 1 | Transmit serial data |
| tx_oe | output | 1 | Transmit output enable |
| rx_bclk | input | 1 | Receive bit clock (level) |
| rx_fs | input | 1 | Receive frame-sync marker |
| rx_sdi | input | 1 | Receive serial data |
| rx_word | output | 8 | Last captured receive byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_word` |

## Verification
The second control byte can land in the same `clk` cycle as the bit-clock rising edge that is a frame marker and would open the transmit slot. The bench provokes this by raising chip-select and sending the first byte in advance, then strobing the second byte in the marker cycle itself. It expects `tx_oe` to stay low through that slot. That marker must not count toward activation, so the port must return only two markers after chip-select falls. Every bit of every frame is compared with a bench-side position model to judge this.

// File: rtl/pcm_tsa_pkg.sv
package pcm_tsa_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_W  = 3;
    localparam int SLOT_W = 6;

    typedef struct packed {
        logic              run;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } frame_pos_t;

    typedef struct packed {
        logic              en;
        logic [SLOT_W-1:0] slot;
    } slot_cfg_t;

    typedef struct packed {
        logic              valid;
        logic              dir;
        logic              dly;
        logic              en;
        logic [SLOT_W-1:0] slot;
    } asg_write_t;

    typedef enum logic [1:0] {
        PR_LIVE    = 2'd0,
        PR_WAIT_CS = 2'd1,
        PR_COUNT   = 2'd2
    } port_state_e;

    // Slot used for a write: non-delayed timing pins the channel to slot 0.
    function automatic logic [SLOT_W-1:0] eff_slot(input logic dly,
                                                  input logic [SLOT_W-1:0] s);
        return dly ? s : '0;
    endfunction

    // MSB-first bit select for bit index idx of a byte.
    function automatic logic msb_first_bit(input logic [BYTE_W-1:0] w,
                                           input logic [BIT_W-1:0] idx);
        return w[~idx];
    endfunction

endpackage

// File: rtl/tsa_edge_det.sv
module tsa_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/tsa_frame_timer.sv
module tsa_frame_timer
    import pcm_tsa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_rise,
    input  logic       fs,
    input  logic       dly,
    output frame_pos_t pos,
    output logic       marker
);
    localparam logic [BIT_W-1:0]  BIT_LAST  = '1;
    localparam logic [SLOT_W-1:0] SLOT_LAST = '1;

    logic fs_prev;
    logic armed;

    assign marker = bit_rise & fs & ~fs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_prev <= 1'b0;
            armed   <= 1'b0;
            pos     <= '0;
        end else if (bit_rise) begin
            fs_prev <= fs;
            if (marker) begin
                if (dly) begin
                    armed   <= 1'b1;
                    pos.run <= 1'b0;
                end else begin
                    armed    <= 1'b0;
                    pos.run  <= 1'b1;
                    pos.slot <= '0;
                    pos.bitn <= '0;
                end
            end else if (armed) begin
                armed    <= 1'b0;
                pos.run  <= 1'b1;
                pos.slot <= '0;
                pos.bitn <= '0;
            end else if (pos.run) begin
                if (pos.bitn == BIT_LAST) begin
                    pos.bitn <= '0;
                    pos.slot <= pos.slot + 1'b1;
                    if (pos.slot == SLOT_LAST) pos.run <= 1'b0;
                end else begin
                    pos.bitn <= pos.bitn + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tsa_port_reg.sv
module tsa_port_reg
    import pcm_tsa_pkg::*;
#(
    parameter int MARK_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              w_dly,
    input  logic              w_en,
    input  logic [SLOT_W-1:0] w_slot,
    input  logic              cs_fall,
    input  logic              marker,
    output slot_cfg_t         cfg,
    output logic              dly,
    output logic              live
);
    localparam int CNT_W = (MARK_N > 2) ? $clog2(MARK_N) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MARK_N - 1);

    port_state_e     state;
    logic [CNT_W-1:0] cnt;
    slot_cfg_t       shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PR_LIVE;
            cnt    <= '0;
            shadow <= '0;
            cfg    <= '{en: 1'b1, slot: '0};
            dly    <= 1'b0;
        end else if (commit) begin
            state       <= PR_WAIT_CS;
            shadow.en   <= w_en;
            shadow.slot <= eff_slot(w_dly, w_slot);
            dly         <= w_dly;
        end else begin
            case (state)
                PR_WAIT_CS: if (cs_fall) begin
                    state <= PR_COUNT;
                    cnt   <= '0;
                end
                PR_COUNT: if (marker) begin
                    if (cnt == CNT_LAST) begin
                        cfg   <= shadow;
                        state <= PR_LIVE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign live = (state == PR_LIVE);
endmodule

// File: rtl/tsa_ctl_decode.sv
module tsa_ctl_decode
    import pcm_tsa_pkg::*;
#(
    parameter logic [5:0] OPCODE = 6'b101101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              wr,
    input  logic [BYTE_W-1:0] data,
    output asg_write_t        req,
    output logic              cs_fall
);
    logic       cs_q;
    logic [1:0] idx;
    logic       op_ok;
    logic       dir_q;
    logic       dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b0;
            idx   <= '0;
            op_ok <= 1'b0;
            dir_q <= 1'b0;
            dly_q <= 1'b0;
        end else begin
            cs_q <= cs;
            if (!cs) begin
                idx <= '0;
            end else if (wr) begin
                if (idx == 2'd0) begin
                    op_ok <= (data[7:2] == OPCODE);
                    dly_q <= data[1];
                    dir_q <= data[0];
                end
                if (idx != 2'd2) idx <= idx + 1'b1;
            end
        end
    end

    assign cs_fall   = cs_q & ~cs;
    assign req.valid = cs & wr & (idx == 2'd1) & op_ok & data[6];
    assign req.dir   = dir_q;
    assign req.dly   = dly_q;
    assign req.en    = data[7];
    assign req.slot  = data[SLOT_W-1:0];
endmodule

// File: rtl/tsa_rx_capture.sv
module tsa_rx_capture
    import pcm_tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_fall,
    input  logic              match,
    input  logic              last_bit,
    input  logic              sdi,
    output logic [BYTE_W-1:0] word,
    output logic              valid
);
    logic [BYTE_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (bit_fall && match) begin
                shreg <= {shreg[BYTE_W-2:0], sdi};
                if (last_bit) begin
                    word  <= {shreg[BYTE_W-2:0], sdi};
                    valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_tsa_ctrl.sv
module pcm_tsa_ctrl
    import pcm_tsa_pkg::*;
#(
    parameter logic [5:0] OPCODE = 6'b101101,
    parameter int         MARK_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_cs,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] ctl_byte,
    input  logic              tx_bclk,
    input  logic              tx_fs,
    input  logic [BYTE_W-1:0] tx_word,
    output logic              tx_sdo,
    output logic              tx_oe,
    input  logic              rx_bclk,
    input  logic              rx_fs,
    input  logic              rx_sdi,
    output logic [BYTE_W-1:0] rx_word,
    output logic              rx_valid
);
    localparam int N_DIR = 2;
    localparam logic [BIT_W-1:0] BIT_LAST = '1;

    asg_write_t       req;
    logic             cs_fall;
    logic [N_DIR-1:0] bclk_v, fs_v;
    logic [N_DIR-1:0] rise_v, fall_v, marker_v, live_v, dly_v, commit_v, match_v;
    frame_pos_t       pos_v [N_DIR];
    slot_cfg_t        cfg_v [N_DIR];

    assign bclk_v = {rx_bclk, tx_bclk};
    assign fs_v   = {rx_fs, tx_fs};

    tsa_ctl_decode #(.OPCODE(OPCODE)) u_ctl (
        .clk(clk), .rst(rst), .cs(ctl_cs), .wr(ctl_wr), .data(ctl_byte),
        .req(req), .cs_fall(cs_fall)
    );

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        assign commit_v[d] = req.valid & (req.dir == 1'(d));

        tsa_edge_det u_edge (
            .clk(clk), .rst(rst), .lvl(bclk_v[d]),
            .rise(rise_v[d]), .fall(fall_v[d])
        );

        tsa_frame_timer u_timer (
            .clk(clk), .rst(rst), .bit_rise(rise_v[d]), .fs(fs_v[d]),
            .dly(dly_v[d]), .pos(pos_v[d]), .marker(marker_v[d])
        );

        tsa_port_reg #(.MARK_N(MARK_N)) u_reg (
            .clk(clk), .rst(rst), .commit(commit_v[d]),
            .w_dly(req.dly), .w_en(req.en), .w_slot(req.slot),
            .cs_fall(cs_fall), .marker(marker_v[d]),
            .cfg(cfg_v[d]), .dly(dly_v[d]), .live(live_v[d])
        );

        assign match_v[d] = pos_v[d].run & live_v[d] & cfg_v[d].en &
                            (pos_v[d].slot == cfg_v[d].slot);
    end

    assign tx_oe  = match_v[0];
    assign tx_sdo = match_v[0] & msb_first_bit(tx_word, pos_v[0].bitn);

    tsa_rx_capture u_rx (
        .clk(clk), .rst(rst), .bit_fall(fall_v[1]), .match(match_v[1]),
        .last_bit(pos_v[1].bitn == BIT_LAST), .sdi(rx_sdi),
        .word(rx_word), .valid(rx_valid)
    );
endmodule

// File: rtl/pcm_tsa_checker.sv
module pcm_tsa_checker (
    input logic clk,
    input logic rst,
    input logic tx_oe,
    input logic rx_valid,
    input logic tx_rise,
    input logic rx_fall,
    input logic tx_commit,
    input logic rx_commit,
    input logic tx_live,
    input logic tx_marker
);
    AST_COMMIT_SILENCES_TX: assert property (@(posedge clk) disable iff (rst)
        tx_commit |=> !tx_oe); // R8

    AST_COMMIT_SILENCES_RX: assert property (@(posedge clk) disable iff (rst)
        rx_commit |=> !rx_valid); // R8

    AST_TX_OE_ON_BIT_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_oe) |-> ($past(tx_rise) || $past(tx_commit))); // R4

    AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R5

    AST_RX_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(rx_fall)); // R5

    AST_LIVE_ON_MARKER: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_live) |-> $past(tx_marker)); // R9
endmodule

bind pcm_tsa_ctrl pcm_tsa_checker u_chk (
    .clk(clk), .rst(rst), .tx_oe(tx_oe), .rx_valid(rx_valid),
    .tx_rise(rise_v[0]), .rx_fall(fall_v[1]),
    .tx_commit(commit_v[0]), .rx_commit(commit_v[1]),
    .tx_live(live_v[0]), .tx_marker(marker_v[0])
);

// File: tb/sim_pcm_tsa_ctrl.sv
module sim_pcm_tsa_ctrl;
    localparam logic [5:0] OP = 6'b101101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_cs = 1'b0, ctl_wr = 1'b0;
    logic [7:0] ctl_byte = '0;
    logic       tx_bclk = 1'b0, tx_fs = 1'b0, rx_bclk = 1'b0, rx_fs = 1'b0, rx_sdi = 1'b0;
    logic [7:0] tx_word = 8'hA5;
    logic [7:0] rx_pat  = 8'h3C;
    logic       tx_sdo, tx_oe, rx_valid;
    logic [7:0] rx_word;

    int n_cmp = 0;
    int n_bad = 0;
    int gbit  = 0;

    // bench-side model, index 0 = transmit, 1 = receive
    bit m_en [2], m_dly [2], m_fsp [2], m_armed [2], m_run [2], sh_en [2];
    int m_slot [2], m_state [2], m_cnt [2], m_pos [2], sh_slot [2];

    always #4 clk = ~clk;

    pcm_tsa_ctrl u0 (
        .clk(clk), .rst(rst), .ctl_cs(ctl_cs), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
        .tx_bclk(tx_bclk), .tx_fs(tx_fs), .tx_word(tx_word), .tx_sdo(tx_sdo), .tx_oe(tx_oe),
        .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_sdi(rx_sdi), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at bit %0d: actual %0h expected %0h", req, what, gbit, act, exp);
        end
    endtask

    function automatic bit exp_match(input int d);
        return m_run[d] && (m_state[d] == 0) && m_en[d] && ((m_pos[d] / 8) == m_slot[d]);
    endfunction

    task automatic model_commit(input int d, input bit dly, input bit en, input int slot);
        m_state[d] = 1;
        sh_en[d]   = en;
        sh_slot[d] = dly ? slot : 0;
        m_dly[d]   = dly;
    endtask

    task automatic model_cs_fall();
        for (int d = 0; d < 2; d++)
            if (m_state[d] == 1) begin m_state[d] = 2; m_cnt[d] = 0; end
    endtask

    task automatic model_rise(input int d, input bit f, input bit commit,
                              input bit dly, input bit en, input int slot);
        bit mk;
        mk = f && !m_fsp[d];
        m_fsp[d] = f;
        if (mk) begin
            if (m_dly[d]) begin m_armed[d] = 1; m_run[d] = 0; end
            else begin m_run[d] = 1; m_pos[d] = 0; m_armed[d] = 0; end
        end else if (m_armed[d]) begin
            m_run[d] = 1; m_pos[d] = 0; m_armed[d] = 0;
        end else if (m_run[d]) begin
            if (m_pos[d] == 511) m_run[d] = 0;
            else m_pos[d]++;
        end
        if (commit) model_commit(d, dly, en, slot);
        else if (m_state[d] == 2 && mk) begin
            if (m_cnt[d] == 1) begin
                m_state[d] = 0; m_en[d] = sh_en[d]; m_slot[d] = sh_slot[d];
            end else m_cnt[d]++;
        end
    endtask

    // one bit period = 4 clk cycles; wr2 strobes the held second byte on the rising edge
    task automatic do_bit(input bit ftx, input bit frx, input bit wr2, input logic [7:0] b1);
        @(negedge clk);
        tx_bclk = 1'b1; rx_bclk = 1'b1; tx_fs = ftx; rx_fs = frx;
        if (wr2) begin ctl_wr = 1'b1; ctl_byte = b1; end
        model_rise(0, ftx, wr2, 1'b0, b1[7], int'(b1[5:0]));
        model_rise(1, frx, 1'b0, 1'b0, 1'b0, 0);
        rx_sdi = exp_match(1) ? rx_pat[7 - (m_pos[1] % 8)] : gbit[0];
        @(negedge clk);
        ctl_wr = 1'b0;
        chk("R4", "tx_oe", 32'(tx_oe), 32'(exp_match(0)));
        if (exp_match(0)) chk("R4", "tx_sdo", 32'(tx_sdo), 32'(tx_word[7 - (m_pos[0] % 8)]));
        else              chk("R4", "tx_sdo idle", 32'(tx_sdo), 32'd0);
        @(negedge clk);
        tx_bclk = 1'b0; rx_bclk = 1'b0;
        @(negedge clk);
        chk("R5", "rx_valid", 32'(rx_valid), 32'(exp_match(1) && (m_pos[1] % 8 == 7)));
        if (rx_valid) chk("R5", "rx_word", 32'(rx_word), 32'(rx_pat));
        gbit++;
    endtask

    task automatic run_frames(input int nfr, input int len, input int tm, input int rm);
        for (int fr = 0; fr < nfr; fr++)
            for (int b = 0; b < len; b++)
                do_bit(b == tm, b == rm, 1'b0, 8'h00);
    endtask

    task automatic wr_cmd(input bit dir, input bit dly, input bit en, input bit ps,
                          input int slot, input int nbytes, input bit opbad);
        logic [7:0] b0, b1;
        b0 = {opbad ? ~OP : OP, dly, dir};
        b1 = {en, ps, 6'(slot)};
        @(negedge clk); ctl_cs = 1'b1;
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            ctl_wr = 1'b1;
            ctl_byte = (i == 0) ? b0 : ((i == 1) ? b1 : 8'hD5);
            if (i == 1 && !opbad && ps) model_commit(int'(dir), dly, en, slot);
        end
        @(negedge clk); ctl_wr = 1'b0;
        chk("R8", "tx_oe after write", 32'(tx_oe), 32'(exp_match(0)));
        @(negedge clk); ctl_cs = 1'b0;
        model_cs_fall();
        @(negedge clk);
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            m_en[d] = 1; m_dly[d] = 0; m_fsp[d] = 0; m_armed[d] = 0; m_run[d] = 0;
            m_slot[d] = 0; m_state[d] = 0; m_cnt[d] = 0; m_pos[d] = 0;
            sh_en[d] = 0; sh_slot[d] = 0;
        end
        repeat (5) @(negedge clk);
        chk("R1", "tx_oe in reset", 32'(tx_oe), 32'd0);
        chk("R1", "rx_valid in reset", 32'(rx_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "tx_sdo after reset", 32'(tx_sdo), 32'd0);

        // R1 R2 R12: default non-delayed slot 0, offset markers
        run_frames(2, 40, 0, 5);
        // R3 R9: tx delayed slot 3
        wr_cmd(1'b0, 1'b1, 1'b1, 1'b1, 3, 2, 1'b0);
        run_frames(3, 48, 2, 7);
        // R7: receive write with port-select 0 is rejected
        wr_cmd(1'b1, 1'b1, 1'b1, 1'b0, 2, 2, 1'b0);
        run_frames(1, 48, 2, 7);
        // R3 R12: receive delayed slot 5
        wr_cmd(1'b1, 1'b1, 1'b1, 1'b1, 5, 2, 1'b0);
        run_frames(3, 64, 1, 9);
        // R11: non-delayed write, slot field 7 disregarded
        tx_word = 8'h6E; rx_pat = 8'hC1;
        wr_cmd(1'b0, 1'b0, 1'b1, 1'b1, 7, 2, 1'b0);
        run_frames(3, 64, 0, 9);
        // R6: wrong opcode, single byte, extra third byte
        wr_cmd(1'b0, 1'b1, 1'b1, 1'b1, 2, 2, 1'b1);
        wr_cmd(1'b0, 1'b1, 1'b1, 1'b1, 2, 1, 1'b0);
        run_frames(1, 64, 0, 9);
        wr_cmd(1'b0, 1'b1, 1'b1, 1'b1, 4, 3, 1'b0);
        run_frames(3, 64, 3, 9);
        // R10: enable 0
        wr_cmd(1'b0, 1'b1, 1'b0, 1'b1, 1, 2, 1'b0);
        run_frames(3, 64, 3, 9);
        // back to non-delayed slot 0
        wr_cmd(1'b0, 1'b0, 1'b1, 1'b1, 0, 2, 1'b0);
        run_frames(3, 64, 0, 9);
        // R8 R9: second byte on the marker edge that opens the slot
        @(negedge clk); ctl_cs = 1'b1;
        @(negedge clk); ctl_wr = 1'b1; ctl_byte = {OP, 1'b0, 1'b0};
        @(negedge clk); ctl_wr = 1'b0;
        do_bit(1'b1, 1'b0, 1'b1, 8'hC0);
        chk("R8", "tx_oe on colliding marker", 32'(tx_oe), 32'd0);
        @(negedge clk); ctl_cs = 1'b0;
        model_cs_fall();
        @(negedge clk);
        for (int b = 1; b < 64; b++) do_bit(1'b0, b == 9, 1'b0, 8'h00);
        run_frames(3, 64, 0, 9);
        // R3: slot 63 and idle tail after the last slot
        tx_word = 8'h99;
        wr_cmd(1'b0, 1'b1, 1'b1, 1'b1, 63, 2, 1'b0);
        run_frames(3, 530, 0, 9);
        wr_cmd(1'b0, 1'b1, 1'b1, 1'b1, 0, 2, 1'b0);
        run_frames(3, 530, 0, 9);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule